// File: doc/BRIEF.md
# Isolated Digital I/O Register Bank

This block is a small byte-wide register file that a host reaches over a plain 8-bit bus. The bus has an address, a write enable, write data and read data. The block holds three bytes of output latches that drive 24 output lines. It also holds one latch byte for a shared 8-bit TTL port. Three read-only bytes return the 24 isolated input lines. Every raw input passes through a two-flop synchronizer before the host reads it, and the synchronized copies also go out to a separate change-of-state detection unit.

One control bit sets the role of the TTL port. When the bit is set, the TTL latch drives the pins and the output enable is high. When the bit is clear, the pins float and the host reads them as inputs. The block decodes the change-of-state status and clear locations and forwards them, but it holds no detection logic itself. A write to the reset location clears every latch in the bank. The same write also sends a one-cycle board reset pulse to the rest of the board.

Top module: `iso_dio_bank`

## Requirements
- R1: While `rst` is high, and on the first idle cycle after it falls, `out_pins`, `ttl_out`, `ttl_oe`, `cos_en`, `cos_clr_mask`, `board_rst` and the read data of offsets 0-3, 12 and 14 are all zero.
- R2: A write to offset 0, 1 or 2 loads output latch byte 0, 1 or 2 (lines 0-7, 8-15, 16-23) at that clock edge. `out_pins` shows the new byte from the next cycle, and a read of the same offset returns it.
- R3: A write to offset 3 loads the TTL latch, and `ttl_out` always equals that latch. `ttl_oe` equals the TTL mode bit of the control register.
- R4: Offsets 4, 5 and 6 return isolated input bytes 0, 1 and 2 after two synchronizer flops. A pin change made before rising edge k shows up in read data updated at edge k+2.
- R5: Offset 7 returns the synchronized TTL pins, with the same latency as in R4, whatever the TTL mode.
- R6: Offset 12 is the control register. Only bit 1 is stored (1 = TTL output mode), and the other bits read back as 0.
- R7: Writes to offsets 4-7 and 13 change no state. Offset 13 always reads 0.
- R8: Any write to offset 15, whatever the data, clears the output latches, the TTL latch, the control register and `cos_en` at that edge. `board_rst` is high for exactly the next cycle.
- R9: Offset 14 is a read/write byte that drives `cos_en` directly.
- R10: Offsets 8-11 return bytes 0-3 of `cos_status`. A write to offset 8+n makes `cos_clr_mask` carry the write data in byte lane n, with zeros in every other lane, for exactly the next cycle. Otherwise `cos_clr_mask` is zero.
- R11: A read of offset 15 returns `irq_pin` in bit 0 and zeros in bits 7:1.
- R12: Read data is registered. The address presented before a rising edge selects the `bus_rdata` that holds from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_pins | output | 24 | Output latch lines |
| iso_in | input | 24 | Raw isolated input lines |
| ttl_in | input | 8 | Raw TTL pin levels |
| ttl_out | output | 8 | TTL latch value to pin drivers |
| ttl_oe | output | 1 | TTL pin output enable |
| iso_sync | output | 24 | Synchronized isolated inputs to detector |
| ttl_sync | output | 8 | Synchronized TTL pins to detector |
| cos_status | input | 32 | Change-of-state status from detector |
| cos_clr_mask | output | 32 | One-cycle clear mask to detector |
| cos_en | output | 8 | Change-of-state enable byte |
| irq_pin | input | 1 | Interrupt output pin level |
| board_rst | output | 1 | One-cycle board reset pulse |

## Verification
The assertions check on every cycle that writes to the output latch byte, the control register and the reset location have their effect on the next cycle. They also check that writes to read-only offsets leave the pins and the enable unchanged, that the reserved location reads zero, and that a clear mask appears only after a write to a status location. Some behaviours can only be shown by the bench scenarios: the exact synchronizer latency of the inputs, the byte lanes of the input and status reads, the dropping of the unused control bits, and the full readback map after a software reset.

// File: rtl/iso_dio_pkg.sv
package iso_dio_pkg;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int OUT_BYTES = 3;
  localparam int IN_BYTES  = 3;
  localparam int COS_BYTES = 4;
  localparam int SYNC_STG  = 2;

  localparam logic [AW-1:0] OFS_OUT0    = 4'd0;
  localparam logic [AW-1:0] OFS_TTL_LAT = 4'd3;
  localparam logic [AW-1:0] OFS_IN0     = 4'd4;
  localparam logic [AW-1:0] OFS_TTL_PIN = 4'd7;
  localparam logic [AW-1:0] OFS_COS0    = 4'd8;
  localparam logic [AW-1:0] OFS_CTL     = 4'd12;
  localparam logic [AW-1:0] OFS_RSVD    = 4'd13;
  localparam logic [AW-1:0] OFS_COS_EN  = 4'd14;
  localparam logic [AW-1:0] OFS_SRST    = 4'd15;
  localparam int            CTL_MODE_BIT = 1;
endpackage

// File: rtl/iso_dio_sync.sv
module iso_dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/iso_dio_regs.sv
module iso_dio_regs
  import iso_dio_pkg::*;
#(
  parameter int NOUT = OUT_BYTES,
  parameter int NCOS = COS_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [NOUT*DW-1:0]   out_lat,
  output logic [DW-1:0]        ttl_lat,
  output logic                 ttl_mode,
  output logic [DW-1:0]        cos_en,
  output logic [NCOS*DW-1:0]   cos_clr,
  output logic                 board_rst
);
  logic soft_wr;
  logic clr;

  assign soft_wr = wr_en && (addr == OFS_SRST);
  assign clr     = rst || soft_wr;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (clr)
        out_lat[g*DW +: DW] <= '0;
      else if (wr_en && addr == (OFS_OUT0 + AW'(g)))
        out_lat[g*DW +: DW] <= wdata;
    end
  end

  for (genvar g = 0; g < NCOS; g++) begin : g_cos
    always_ff @(posedge clk) begin
      if (rst)
        cos_clr[g*DW +: DW] <= '0;
      else if (wr_en && addr == (OFS_COS0 + AW'(g)))
        cos_clr[g*DW +: DW] <= wdata;
      else
        cos_clr[g*DW +: DW] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ttl_lat  <= '0;
      ttl_mode <= 1'b0;
      cos_en   <= '0;
    end else if (wr_en) begin
      if (addr == OFS_TTL_LAT) ttl_lat  <= wdata;
      if (addr == OFS_CTL)     ttl_mode <= wdata[CTL_MODE_BIT];
      if (addr == OFS_COS_EN)  cos_en   <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) board_rst <= 1'b0;
    else     board_rst <= soft_wr;
  end
endmodule

// File: rtl/iso_dio_rdmux.sv
module iso_dio_rdmux
  import iso_dio_pkg::*;
#(
  parameter int NOUT = OUT_BYTES,
  parameter int NIN  = IN_BYTES,
  parameter int NCOS = COS_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr,
  input  logic [NOUT*DW-1:0] out_lat,
  input  logic [DW-1:0]      ttl_lat,
  input  logic [NIN*DW-1:0]  iso_s,
  input  logic [DW-1:0]      ttl_s,
  input  logic [NCOS*DW-1:0] cos_status,
  input  logic               ttl_mode,
  input  logic [DW-1:0]      cos_en,
  input  logic               irq_pin,
  output logic [DW-1:0]      rdata
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < NOUT; i++)
      if (addr == OFS_OUT0 + AW'(i)) nxt = out_lat[i*DW +: DW];
    for (int i = 0; i < NIN; i++)
      if (addr == OFS_IN0 + AW'(i)) nxt = iso_s[i*DW +: DW];
    for (int i = 0; i < NCOS; i++)
      if (addr == OFS_COS0 + AW'(i)) nxt = cos_status[i*DW +: DW];
    if (addr == OFS_TTL_LAT) nxt = ttl_lat;
    if (addr == OFS_TTL_PIN) nxt = ttl_s;
    if (addr == OFS_CTL)     nxt = DW'(ttl_mode) << CTL_MODE_BIT;
    if (addr == OFS_COS_EN)  nxt = cos_en;
    if (addr == OFS_SRST)    nxt = DW'(irq_pin);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/iso_dio_bank.sv
module iso_dio_bank
  import iso_dio_pkg::*;
#(
  parameter int NOUT = OUT_BYTES,
  parameter int NIN  = IN_BYTES,
  parameter int NCOS = COS_BYTES,
  parameter int NSYNC = SYNC_STG
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_we,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic [NOUT*DW-1:0]   out_pins,
  input  logic [NIN*DW-1:0]    iso_in,
  input  logic [DW-1:0]        ttl_in,
  output logic [DW-1:0]        ttl_out,
  output logic                 ttl_oe,
  output logic [NIN*DW-1:0]    iso_sync,
  output logic [DW-1:0]        ttl_sync,
  input  logic [NCOS*DW-1:0]   cos_status,
  output logic [NCOS*DW-1:0]   cos_clr_mask,
  output logic [DW-1:0]        cos_en,
  input  logic                 irq_pin,
  output logic                 board_rst
);
  logic [NOUT*DW-1:0] out_lat;
  logic [DW-1:0]      ttl_lat;
  logic               ttl_mode;

  iso_dio_sync #(.W(NIN*DW), .STAGES(NSYNC)) u_sync_iso (
    .clk(clk), .rst(rst), .d(iso_in), .q(iso_sync));

  iso_dio_sync #(.W(DW), .STAGES(NSYNC)) u_sync_ttl (
    .clk(clk), .rst(rst), .d(ttl_in), .q(ttl_sync));

  iso_dio_regs #(.NOUT(NOUT), .NCOS(NCOS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .out_lat(out_lat), .ttl_lat(ttl_lat), .ttl_mode(ttl_mode),
    .cos_en(cos_en), .cos_clr(cos_clr_mask), .board_rst(board_rst));

  iso_dio_rdmux #(.NOUT(NOUT), .NIN(NIN), .NCOS(NCOS)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .out_lat(out_lat),
    .ttl_lat(ttl_lat), .iso_s(iso_sync), .ttl_s(ttl_sync),
    .cos_status(cos_status), .ttl_mode(ttl_mode), .cos_en(cos_en),
    .irq_pin(irq_pin), .rdata(bus_rdata));

  assign out_pins = out_lat;
  assign ttl_out  = ttl_lat;
  assign ttl_oe   = ttl_mode;
endmodule

// File: rtl/iso_dio_bank_chk.sv
module iso_dio_bank_chk
  import iso_dio_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic [AW-1:0]            bus_addr,
  input logic                     bus_we,
  input logic [DW-1:0]            bus_wdata,
  input logic [DW-1:0]            bus_rdata,
  input logic [OUT_BYTES*DW-1:0]  out_pins,
  input logic                     ttl_oe,
  input logic [COS_BYTES*DW-1:0]  cos_clr_mask,
  input logic [DW-1:0]            cos_en,
  input logic                     board_rst
);
  p_out_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_OUT0) |=> (out_pins[DW-1:0] == $past(bus_wdata)));

  p_oe_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_CTL) |=> (ttl_oe == $past(bus_wdata[CTL_MODE_BIT])));

  p_ro_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && ((bus_addr >= OFS_IN0 && bus_addr <= OFS_TTL_PIN) || bus_addr == OFS_RSVD))
    |=> ($stable(out_pins) && $stable(ttl_oe) && $stable(cos_en)));

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_RSVD) |=> (bus_rdata == '0));

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_SRST)
    |=> (out_pins == '0 && !ttl_oe && cos_en == '0 && board_rst));

  p_clr_source_r10: assert property (@(posedge clk) disable iff (rst)
    (cos_clr_mask != '0)
    |-> ($past(bus_we) && $past(bus_addr) >= OFS_COS0 && $past(bus_addr) < OFS_CTL));
endmodule

bind iso_dio_bank iso_dio_bank_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_pins(out_pins),
  .ttl_oe(ttl_oe), .cos_clr_mask(cos_clr_mask), .cos_en(cos_en),
  .board_rst(board_rst));

// File: tb/iso_dio_bank_bench.sv
module iso_dio_bank_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] out_pins;
  logic [23:0] iso_in = '0;
  logic [7:0]  ttl_in = '0;
  logic [7:0]  ttl_out;
  logic        ttl_oe;
  logic [23:0] iso_sync;
  logic [7:0]  ttl_sync;
  logic [31:0] cos_status = '0;
  logic [31:0] cos_clr_mask;
  logic [7:0]  cos_en;
  logic        irq_pin = 1'b0;
  logic        board_rst;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp;
    string      req;
  } rd_item_t;
  rd_item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_dio_bank u_iso_dio_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_pins(out_pins),
    .iso_in(iso_in), .ttl_in(ttl_in), .ttl_out(ttl_out), .ttl_oe(ttl_oe),
    .iso_sync(iso_sync), .ttl_sync(ttl_sync), .cos_status(cos_status),
    .cos_clr_mask(cos_clr_mask), .cos_en(cos_en), .irq_pin(irq_pin),
    .board_rst(board_rst));

  // Monitor: the read data for an item pushed before a rising edge is registered at that edge (R12)
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      n_run++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s read of offset %0d: actual %02h expected %02h",
                 it.req, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string req);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    it.addr = a; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'd13;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", out_pins, 0);
    chk("R1 oe in reset", {31'd0, ttl_oe}, 0);
    rst = 1'b0;
    idle();
    chk("R1 idle outputs", {out_pins, ttl_out}, 0);
    chk("R1 enables", {cos_en, 7'd0, ttl_oe, 7'd0, board_rst}, 0);
    chk("R1 clr mask", cos_clr_mask, 0);
    rd(4'd0, 8'h00, "R1");
    rd(4'd3, 8'h00, "R1");
    rd(4'd12, 8'h00, "R1");
    rd(4'd14, 8'h00, "R1");

    // R2 output latches
    wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd2, 8'hF0);
    idle();
    chk("R2 out_pins", out_pins, 32'hF03CA5);
    rd(4'd0, 8'hA5, "R2"); rd(4'd1, 8'h3C, "R2"); rd(4'd2, 8'hF0, "R2");

    // R3 TTL latch and output enable
    wr(4'd3, 8'h5A);
    idle();
    chk("R3 ttl_out", ttl_out, 8'h5A);
    chk("R3 oe off", ttl_oe, 0);
    rd(4'd3, 8'h5A, "R3");
    wr(4'd12, 8'h02);
    idle();
    chk("R3 oe on", ttl_oe, 1);
    rd(4'd12, 8'h02, "R6");
    wr(4'd12, 8'hFD);
    idle();
    chk("R6 only bit1 sets mode", ttl_oe, 0);
    rd(4'd12, 8'h00, "R6");

    // R4 isolated inputs with sync latency
    @(negedge clk); iso_in = 24'h123456;
    idle();
    rd(4'd4, 8'h56, "R4"); rd(4'd5, 8'h34, "R4"); rd(4'd6, 8'h12, "R4");
    @(negedge clk); iso_in = 24'h123499;
    rd(4'd4, 8'h56, "R4 latency old");
    rd(4'd4, 8'h99, "R4 latency new");

    // R5 TTL pins in input mode and output mode
    @(negedge clk); ttl_in = 8'hC3;
    idle();
    rd(4'd7, 8'hC3, "R5");
    wr(4'd12, 8'h02);
    @(negedge clk); ttl_in = 8'h3E; bus_we = 1'b0;
    idle();
    rd(4'd7, 8'h3E, "R5 output mode");

    // R7 read-only and reserved offsets
    wr(4'd4, 8'hFF); wr(4'd7, 8'hFF); wr(4'd13, 8'hFF);
    idle();
    chk("R7 pins unchanged", out_pins, 32'hF03CA5);
    chk("R7 oe unchanged", ttl_oe, 1);
    rd(4'd4, 8'h99, "R7"); rd(4'd13, 8'h00, "R7"); rd(4'd3, 8'h5A, "R7");

    // R9 enable byte
    wr(4'd14, 8'h11);
    idle();
    chk("R9 cos_en", cos_en, 8'h11);
    rd(4'd14, 8'h11, "R9");

    // R10 status read and clear mask
    cos_status = 32'hDEADBEEF;
    rd(4'd8, 8'hEF, "R10"); rd(4'd11, 8'hDE, "R10");
    wr(4'd9, 8'hA5);
    idle();
    chk("R10 clr lane1", cos_clr_mask, 32'h0000A500);
    idle();
    chk("R10 clr one cycle", cos_clr_mask, 0);

    // R11 interrupt pin status
    irq_pin = 1'b1;
    rd(4'd15, 8'h01, "R11");
    @(negedge clk); irq_pin = 1'b0;
    rd(4'd15, 8'h00, "R11");

    // R8 software reset
    wr(4'd15, 8'h00);
    idle();
    chk("R8 board_rst", board_rst, 1);
    chk("R8 pins cleared", {out_pins, ttl_out}, 0);
    chk("R8 oe/en cleared", {cos_en, 7'd0, ttl_oe}, 0);
    idle();
    chk("R8 pulse ends", board_rst, 0);
    rd(4'd0, 8'h00, "R8"); rd(4'd3, 8'h00, "R8");
    rd(4'd12, 8'h00, "R8"); rd(4'd14, 8'h00, "R8");

    idle(); idle(); idle();
    chk("R12 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule